// File: doc/BRIEF.md
# Sense-Reversing Barrier Synchronizer

This block lets a group of `N_PART` agents meet at a common point before any of them goes on. An agent announces that it has reached the barrier with a one-cycle arrive pulse, and it sends its local sense bit on the same cycle. The agent flips that bit before each new episode. The block latches the sense of every counted arrival and counts the arrivals. It also holds a single global release flag. An agent has passed the barrier when the global flag equals its latched sense. The block shows this on a per-agent `released_o` output.

When the arrivals of a cycle bring the count up to `N_PART`, the count returns to zero and the global flag takes the sense that the arrivals carried. The per-agent arrival marks are cleared at the same time, so the next episode can start at once. The flag only ever moves to the new sense of the finishing episode. A fast agent that re-enters the next episode with its flipped sense therefore drops only its own `released_o`, and the agents that are still leaving keep theirs. Several arrivals in one cycle are each counted once. A second arrival from an agent that is already marked in the current episode is rejected and reported.

Top module: `sbar_top`

## Requirements
- R1: After reset the release flag is 0, the count is 0, every latched sense is 0 (so every `released_o` bit is 1), and no `dup_err_o` bit is set.
- R2: One accepted arrival raises `count_o` by one on the next cycle, and that agent's latched sense becomes the sense it sent.
- R3: When k distinct, not-yet-marked agents arrive in the same cycle, `count_o` rises by exactly k on the next cycle, provided the total stays below `N_PART`.
- R4: When the accepted arrivals of a cycle bring the count to `N_PART`, the next cycle shows `count_o` = 0 and `release_sense_o` equal to the sense sent by the lowest-numbered accepted arrival of that cycle. Outside this event the flag does not change.
- R5: Each `released_o[i]` is 1 exactly when `release_sense_o` equals agent i's latched sense.
- R6: An arrival from an agent already marked in the current episode is not counted and does not change its latched sense. It sets `dup_err_o[i]` for exactly the following cycle. This also holds in a cycle where other agents complete the episode.
- R7: Completing an episode clears all arrival marks, so on the very next cycle every agent can arrive again and is counted.
- R8: An agent that re-enters a new episode with its flipped sense clears only its own `released_o` bit. The flag and every other agent's `released_o` stay unchanged until that episode completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arrive_i | input | N_PART | One-cycle arrival pulse per agent |
| sense_i | input | N_PART | Local sense sent with the arrival |
| release_sense_o | output | 1 | Global release flag |
| count_o | output | CNT_W | Arrivals counted in the current episode |
| released_o | output | N_PART | Per-agent passed indication |
| dup_err_o | output | N_PART | Per-agent duplicate-arrival error, one cycle |

## Verification
The bench builds the block with `N_PART` = 4. With that value an episode completes in one to four cycles, and a single cycle with all four agents arriving reaches the full count from zero. The small size also makes it cheap to run several back-to-back episodes in both sense polarities. It covers a mixed-sense completion that shows the lowest-index rule, and a duplicate that lands in the same cycle as completion.

// File: rtl/sbar_pkg.sv
package sbar_pkg;
  // Width that can hold any value from 0 up to n inclusive.
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sbar_popcount.sv
module sbar_popcount #(
  parameter int N = 8,
  parameter int W = 4
) (
  input  logic [N-1:0] bits_i,
  output logic [W-1:0] sum_o
);
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++) begin
      sum_o = sum_o + {{(W-1){1'b0}}, bits_i[i]};
    end
  end
endmodule

// File: rtl/sbar_slot.sv
module sbar_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arrive_i,
  input  logic sense_i,
  input  logic clear_i,
  input  logic flag_i,
  output logic counted_o,
  output logic released_o,
  output logic dup_err_o
);
  logic arrived_q, arrived_d;
  logic sense_q, sense_d;
  logic dup_q, dup_d;
  logic sense_en;

  // next state
  always_comb begin
    counted_o = arrive_i & ~arrived_q;
    sense_en  = counted_o;
    sense_d   = sense_i;
    arrived_d = clear_i ? 1'b0 : (arrived_q | counted_o);
    dup_d     = arrive_i & arrived_q;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arrived_q <= 1'b0;
      sense_q   <= 1'b0;
      dup_q     <= 1'b0;
    end else begin
      arrived_q <= arrived_d;
      dup_q     <= dup_d;
      if (sense_en) sense_q <= sense_d;
    end
  end

  assign released_o = ~(flag_i ^ sense_q);
  assign dup_err_o  = dup_q;

  // R6: a rejected arrival leaves the latched sense alone
  a_r6_dup_keeps_sense: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arrive_i && arrived_q) |=> (sense_q == $past(sense_q)));

  // R7: episode end clears the arrival mark
  a_r7_mark_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !arrived_q);
endmodule

// File: rtl/sbar_core.sv
module sbar_core #(
  parameter int N = 8,
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] counted_i,
  input  logic [N-1:0] sense_i,
  output logic [W-1:0] count_o,
  output logic         flag_o,
  output logic         done_o
);
  typedef logic [W:0] sum_t;
  localparam sum_t TOTAL = sum_t'(N);

  logic [W-1:0] inc;
  logic [W-1:0] count_q, count_d;
  logic         flag_q, flag_d;
  sum_t         total;
  logic         win_sense;
  logic         found;

  sbar_popcount #(.N(N), .W(W)) u_pop (
    .bits_i (counted_i),
    .sum_o  (inc)
  );

  // lowest-index accepted arrival decides the new flag
  always_comb begin
    win_sense = 1'b0;
    found     = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (counted_i[i] && !found) begin
        win_sense = sense_i[i];
        found     = 1'b1;
      end
    end
  end

  // next state
  always_comb begin
    total   = {1'b0, count_q} + {1'b0, inc};
    done_o  = (total == TOTAL);
    count_d = done_o ? '0 : total[W-1:0];
    flag_d  = done_o ? win_sense : flag_q;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      flag_q  <= flag_d;
    end
  end

  assign count_o = count_q;
  assign flag_o  = flag_q;

  // R2: count never reaches the total in a stored state
  a_r2_count_below_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, count_q} < TOTAL));

  // R3: without completion the count never falls
  a_r3_count_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(done_o) |-> (count_q >= $past(count_q)));

  // R4: the flag only moves when the count has just wrapped
  a_r4_flag_moves_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flag_q) |-> (count_q == '0));
endmodule

// File: rtl/sbar_top.sv
module sbar_top import sbar_pkg::*; #(
  parameter  int N_PART = 8,
  localparam int CNT_W  = cnt_bits(N_PART)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PART-1:0] arrive_i,
  input  logic [N_PART-1:0] sense_i,
  output logic              release_sense_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [N_PART-1:0] released_o,
  output logic [N_PART-1:0] dup_err_o
);
  logic [N_PART-1:0] counted;
  logic              flag;
  logic              done;

  for (genvar g = 0; g < N_PART; g++) begin : g_slot
    sbar_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .arrive_i   (arrive_i[g]),
      .sense_i    (sense_i[g]),
      .clear_i    (done),
      .flag_i     (flag),
      .counted_o  (counted[g]),
      .released_o (released_o[g]),
      .dup_err_o  (dup_err_o[g])
    );
  end

  sbar_core #(.N(N_PART), .W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .counted_i (counted),
    .sense_i   (sense_i),
    .count_o   (count_o),
    .flag_o    (flag),
    .done_o    (done)
  );

  assign release_sense_o = flag;

  // R6: an error pulse lasts a single cycle unless re-triggered
  a_r6_err_from_arrival: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dup_err_o != '0) |-> ((dup_err_o & ~$past(arrive_i)) == '0));

  // R7: after completion the next cycle starts from an empty count
  a_r7_restart_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (count_o == '0));
endmodule

// File: tb/sbar_top_tb_top.sv
module sbar_top_tb_top;
  localparam int NP = 4;
  localparam int CW = 3;

  typedef struct {
    logic          flag;
    logic [CW-1:0] cnt;
    logic [NP-1:0] rel;
    logic [NP-1:0] err;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] arrive = '0;
  logic [NP-1:0] sense = '0;
  logic          flag_o;
  logic [CW-1:0] cnt_o;
  logic [NP-1:0] rel_o;
  logic [NP-1:0] err_o;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;
  exp_t q[$];

  // model state, from the requirements
  logic          m_flag = 1'b0;
  logic [CW-1:0] m_cnt = '0;
  logic [NP-1:0] m_sense = '0;
  logic [NP-1:0] m_arr = '0;

  always #4 clk = ~clk;

  sbar_top #(.N_PART(NP)) dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .arrive_i        (arrive),
    .sense_i         (sense),
    .release_sense_o (flag_o),
    .count_o         (cnt_o),
    .released_o      (rel_o),
    .dup_err_o       (err_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(input logic [NP-1:0] a, input logic [NP-1:0] s,
                       input string tag);
    exp_t          e;
    logic [NP-1:0] ok_arr;
    int            k;
    logic          win;
    bit            got;
    @(negedge clk);
    arrive = a;
    sense  = s;
    ok_arr = a & ~m_arr;
    e.err  = a & m_arr;
    k      = $countones(ok_arr);
    win    = 1'b0;
    got    = 1'b0;
    for (int i = 0; i < NP; i++) begin
      if (ok_arr[i]) begin
        m_sense[i] = s[i];
        if (!got) begin win = s[i]; got = 1'b1; end
      end
    end
    if (int'(m_cnt) + k == NP) begin
      m_cnt  = '0;
      m_flag = win;
      m_arr  = '0;
    end else begin
      m_cnt = m_cnt + CW'(k);
      m_arr = m_arr | ok_arr;
    end
    e.flag = m_flag;
    e.cnt  = m_cnt;
    e.rel  = ~(m_sense ^ {NP{m_flag}});
    e.tag  = tag;
    q.push_back(e);
  endtask

  // monitor: compares each result once the registers have updated
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(flag_o == e.flag, e.tag, "flag",  int'(flag_o), int'(e.flag));
        check(cnt_o  == e.cnt,  e.tag, "count", int'(cnt_o),  int'(e.cnt));
        check(rel_o  == e.rel,  e.tag, "released", int'(rel_o), int'(e.rel));
        check(err_o  == e.err,  e.tag, "dup_err", int'(err_o), int'(e.err));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(flag_o == 1'b0, "R1", "flag", int'(flag_o), 0);
    check(cnt_o == '0, "R1", "count", int'(cnt_o), 0);
    check(rel_o == '1, "R1", "released", int'(rel_o), 'hF);
    check(err_o == '0, "R1", "dup_err", int'(err_o), 0);
    drive(4'b0000, 4'b0000, "R1");
    // episode 1, new sense 1
    drive(4'b0001, 4'b1111, "R2");
    drive(4'b0001, 4'b0000, "R6");         // duplicate, wrong sense ignored
    drive(4'b0110, 4'b1111, "R3");
    drive(4'b0000, 4'b0000, "R5");
    drive(4'b1000, 4'b1111, "R4");
    // episode 2, new sense 0: fast agent re-enters
    drive(4'b0001, 4'b0000, "R8");
    drive(4'b0000, 4'b0000, "R8");
    drive(4'b1110, 4'b0000, "R3");
    // episode 3: all at once, straight after completion
    drive(4'b1111, 4'b1111, "R7");
    drive(4'b0000, 4'b0000, "R5");
    // episode 4: mixed senses, lowest index wins
    drive(4'b0010, 4'b0000, "R2");
    drive(4'b0100, 4'b0100, "R3");
    drive(4'b1001, 4'b0001, "R4");
    // episode 5: duplicate in the completing cycle
    drive(4'b0001, 4'b0000, "R2");
    drive(4'b1111, 4'b0000, "R6");
    drive(4'b0000, 4'b0000, "R6");
    // episode 6: duplicate alone, then completion
    drive(4'b0011, 4'b0011, "R3");
    drive(4'b0010, 4'b0000, "R6");
    drive(4'b1100, 4'b1100, "R4");
    drive(4'b0000, 4'b0000, "R5");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule